// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Core

This block is a small 32-bit processor core that runs every instruction to completion in one clock period. In that period it fetches a word from its internal instruction array, splits the word into fields, reads two source registers, runs the ALU, optionally reads or writes its internal data array, writes back to the register file, and selects the next program counter. Nine operations are implemented: register add, subtract, AND, OR and signed set-less-than, add-immediate, word load, word store, and branch-if-equal.

The instruction array and the data array are plain word arrays inside the core. The instruction array starts out all zero, and the testbench writes the program into it before reset is released. The data array is filled only by the program's own stores. Instructions are not visible at the ports. The only view of execution is the current program counter and a tap that shows, in the same cycle, any register write the executing instruction makes. Branch targets come from an adder of their own, so the ALU stays free for the equality subtraction.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes 0 and no register or memory write takes place. The first instruction after reset is fetched from byte address 0.
- R2: A word whose opcode (bits 31:26) is 0x00 is a register operation. Its funct field (bits 5:0) selects the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than. The operands come from rs (bits 25:21) and rt (bits 20:16), and the result goes to rd (bits 15:11).
- R3: Opcode 0x08 adds the sign-extended 16-bit immediate (bits 15:0) to R[rs] and writes the sum to rt.
- R4: Opcode 0x2B stores R[rt] at byte address R[rs] + sign_extend(imm) and writes no register. Opcode 0x23 loads the word at that address into rt. A stored word can be read back by a later load.
- R5: The data array is indexed by address bits [DMEM_AW+1:2]. The two low address bits are ignored, and so are the bits above the index.
- R6: Register 0 reads as zero. An instruction that targets register 0 still shows its write on the tap, but later reads of register 0 return zero.
- R7: Every instruction other than a taken branch moves the program counter to PC + 4.
- R8: Opcode 0x04 compares R[rs] with R[rt]. When they are equal, the next PC is PC + 4 + (sign_extend(imm) << 2), which may lie backwards. When they differ, the next PC is PC + 4. A branch writes no register.
- R9: In the cycle in which an instruction executes, `wb_en_o`, `wb_addr_o` and `wb_data_o` show its register write: the enable, the destination and the value. The register file holds that value from the next edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| pc_o | output | 32 | Byte address of the instruction now executing |
| wb_en_o | output | 1 | High when the executing instruction writes a register |
| wb_addr_o | output | 5 | Destination register of that write |
| wb_data_o | output | 32 | Value being written |

## Verification
The bench builds the core with its default sizes: 64-word instruction and data arrays (IMEM_AW = DMEM_AW = 6). With these sizes, a 256-byte data window lies inside the reach of a 16-bit immediate. A load at an offset above that window is therefore expected to alias onto a word stored earlier, and so is a load whose address has its two low bits set. The short programs also cover a forward taken branch that skips two words, a not-taken branch, and a backward branch that forms a two-instruction loop.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

    localparam int XLEN   = 32;
    localparam int REG_AW = 5;
    localparam int NREGS  = 1 << REG_AW;

    typedef enum logic [5:0] {
        OPC_RTYPE = 6'h00,
        OPC_BEQ   = 6'h04,
        OPC_ADDI  = 6'h08,
        OPC_LOAD  = 6'h23,
        OPC_STORE = 6'h2B
    } opcode_e;

    typedef enum logic [5:0] {
        FN_ADD = 6'h20,
        FN_SUB = 6'h22,
        FN_AND = 6'h24,
        FN_OR  = 6'h25,
        FN_SLT = 6'h2A
    } funct_e;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_SLT
    } alu_op_e;

    // Field view of a register-format word; the immediate overlays bits 15:0
    typedef struct packed {
        logic [5:0]        op;
        logic [REG_AW-1:0] rs;
        logic [REG_AW-1:0] rt;
        logic [REG_AW-1:0] rd;
        logic [4:0]        shamt;
        logic [5:0]        funct;
    } rfields_t;

    typedef struct packed {
        logic    reg_write;
        logic    dst_rd;     // destination is rd (else rt)
        logic    src_imm;    // ALU second operand is the immediate
        logic    mem_write;
        logic    mem_read;
        logic    branch;
        alu_op_e alu_op;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_core_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl = '{reg_write: 1'b0, dst_rd: 1'b0, src_imm: 1'b0, mem_write: 1'b0,
                 mem_read: 1'b0, branch: 1'b0, alu_op: ALU_ADD};
        case (op)
            OPC_RTYPE: begin
                ctrl.dst_rd = 1'b1;
                ctrl.reg_write = 1'b1;
                case (funct)
                    FN_ADD:  ctrl.alu_op = ALU_ADD;
                    FN_SUB:  ctrl.alu_op = ALU_SUB;
                    FN_AND:  ctrl.alu_op = ALU_AND;
                    FN_OR:   ctrl.alu_op = ALU_OR;
                    FN_SLT:  ctrl.alu_op = ALU_SLT;
                    default: ctrl.reg_write = 1'b0;  // unknown function: no effect
                endcase
            end
            OPC_ADDI: begin
                ctrl.reg_write = 1'b1;
                ctrl.src_imm = 1'b1;
            end
            OPC_LOAD: begin
                ctrl.reg_write = 1'b1;
                ctrl.src_imm = 1'b1;
                ctrl.mem_read = 1'b1;
            end
            OPC_STORE: begin
                ctrl.src_imm = 1'b1;
                ctrl.mem_write = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.branch = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sc_core_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int AW = REG_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    localparam int DEPTH = 1 << AW;

    logic [W-1:0] regs [DEPTH];

    // Index 0 is never stored; reads of it are forced to zero
    always_ff @(posedge clk) begin
        if (we && wa != '0) regs[wa] <= wd;
    end

    assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

    // R9: a write to a non-zero register is held from the next edge on
    a_r9_write_lands: assert property (@(posedge clk) disable iff (rst)
        (we && wa != '0) |=> regs[$past(wa)] == $past(wd));

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_core_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);

    always_comb begin
        case (op)
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_core_pkg::*;
#(
    parameter int IMEM_AW = 6,
    parameter int DMEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    output logic [XLEN-1:0]   pc_o,
    output logic              wb_en_o,
    output logic [REG_AW-1:0] wb_addr_o,
    output logic [XLEN-1:0]   wb_data_o
);

    localparam int IMEM_WORDS = 1 << IMEM_AW;
    localparam int DMEM_WORDS = 1 << DMEM_AW;

    logic [XLEN-1:0] imem [IMEM_WORDS];
    logic [XLEN-1:0] dmem [DMEM_WORDS];

    // Instruction store starts cleared; the program is written in before reset ends
    initial begin
        for (int i = 0; i < IMEM_WORDS; i++) imem[i] = '0;
    end

    logic [XLEN-1:0]   pc_q, pc_plus4, br_target, pc_next;
    logic [XLEN-1:0]   instr, imm_sext;
    rfields_t          f;
    ctrl_t             ctrl;
    logic [XLEN-1:0]   rs_val, rt_val, alu_b, alu_y, load_data, wb_data;
    logic [REG_AW-1:0] wb_addr;
    logic              alu_zero, br_taken, wb_en;
    logic [DMEM_AW-1:0] d_idx;

    // Fetch and field split
    assign instr    = imem[pc_q[IMEM_AW+1:2]];
    assign f        = rfields_t'(instr);
    assign imm_sext = sext16(instr[15:0]);

    sc_decode u_dec (
        .op    (f.op),
        .funct (f.funct),
        .ctrl  (ctrl)
    );

    assign wb_addr = ctrl.dst_rd ? f.rd : f.rt;
    assign wb_en   = ctrl.reg_write & ~rst;
    assign wb_data = ctrl.mem_read ? load_data : alu_y;

    sc_regfile #(.W(XLEN), .AW(REG_AW)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .ra_a (f.rs),
        .ra_b (f.rt),
        .rd_a (rs_val),
        .rd_b (rt_val),
        .we   (wb_en),
        .wa   (wb_addr),
        .wd   (wb_data)
    );

    assign alu_b = ctrl.src_imm ? imm_sext : rt_val;

    sc_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // Data memory: word index taken from the effective address
    assign d_idx     = alu_y[DMEM_AW+1:2];
    assign load_data = dmem[d_idx];

    always_ff @(posedge clk) begin
        if (ctrl.mem_write && !rst) dmem[d_idx] <= rt_val;
    end

    // Next PC: a dedicated adder forms the branch target
    assign pc_plus4  = pc_q + XLEN'(4);
    assign br_target = pc_plus4 + {imm_sext[XLEN-3:0], 2'b00};
    assign br_taken  = ctrl.branch & alu_zero;
    assign pc_next   = br_taken ? br_target : pc_plus4;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    assign pc_o      = pc_q;
    assign wb_en_o   = wb_en;
    assign wb_addr_o = wb_addr;
    assign wb_data_o = wb_data;

    logic unused_bits;
    assign unused_bits = ^{f.shamt, pc_q[1:0], pc_q[XLEN-1:IMEM_AW+2],
                           alu_y[1:0], alu_y[XLEN-1:DMEM_AW+2]};

    // R7: sequential flow advances by one word
    a_r7_seq_pc: assert property (@(posedge clk) disable iff (rst)
        !br_taken |=> pc_q == $past(pc_q) + 32'd4);

    // R8: a taken branch lands on PC + 4 + offset*4
    a_r8_branch_pc: assert property (@(posedge clk) disable iff (rst)
        br_taken |=> pc_q == $past(pc_q) + 32'd4 + ($past(imm_sext) << 2));

    // R8: taken only when the register file supplied equal operands
    a_r8_taken_equal: assert property (@(posedge clk) disable iff (rst)
        br_taken |-> rs_val == rt_val);

    // R4: a store's data is in the array after the edge
    a_r4_store_lands: assert property (@(posedge clk) disable iff (rst)
        ctrl.mem_write |=> dmem[$past(d_idx)] == $past(rt_val));

    // R4 / R8: stores and branches show no register write
    a_r4_no_wb_store_branch: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mem_write || ctrl.branch) |-> !wb_en_o);

    // R6: register 0 as a source always yields zero
    a_r6_zero_source: assert property (@(posedge clk) disable iff (rst)
        (f.rs == '0) |-> rs_val == '0);

endmodule

// File: tb/sc_core_test.sv
module sc_core_test;
    import sc_core_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_o;
    logic        wb_en_o;
    logic [4:0]  wb_addr_o;
    logic [31:0] wb_data_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] prog [64];

    always #10 clk = ~clk;   // 50 MHz

    sc_core uut (
        .clk       (clk),
        .rst       (rst),
        .pc_o      (pc_o),
        .wb_en_o   (wb_en_o),
        .wb_addr_o (wb_addr_o),
        .wb_data_o (wb_data_o)
    );

    function automatic logic [31:0] rr(input logic [5:0] fn, input int rd, input int rs, input int rt);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction

    function automatic logic [31:0] ii(input logic [5:0] op, input int rt, input int rs, input int imm);
        return {op, rs[4:0], rt[4:0], imm[15:0]};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 64; i++) prog[i] = 32'h0;
    endtask

    // Load the program, hold reset two edges, release at a falling edge
    task automatic start();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 64; i++) uut.imem[i] = prog[i];
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Check the executing instruction's PC and tap, then advance one cycle
    task automatic step(input string tag, input logic [31:0] epc, input logic een,
                        input logic [4:0] ea, input logic [31:0] ed);
        #2;
        chk({tag, " pc"}, pc_o, epc);
        chk({tag, " wb_en"}, {31'd0, wb_en_o}, {31'd0, een});
        if (een) begin
            chk({tag, " wb_addr"}, {27'd0, wb_addr_o}, {27'd0, ea});
            chk({tag, " wb_data"}, wb_data_o, ed);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic test_reset();
        clear_prog();
        prog[0] = ii(OPC_ADDI, 1, 0, 5);
        @(negedge clk);
        for (int i = 0; i < 64; i++) uut.imem[i] = prog[i];
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 pc held at 0", pc_o, 32'h0);
        chk("R1 no write in reset", {31'd0, wb_en_o}, 32'h0);
        @(posedge clk);
        @(negedge clk);
        chk("R1 pc still 0", pc_o, 32'h0);
        rst = 1'b0;
        step("R1 first fetch", 32'h0, 1'b1, 5'd1, 32'd5);
        step("R7 after first", 32'h4, 1'b0, 5'd0, 32'd0);
    endtask

    task automatic test_alu();
        clear_prog();
        prog[0] = ii(OPC_ADDI, 1, 0, 7);
        prog[1] = ii(OPC_ADDI, 2, 0, -3);
        prog[2] = rr(FN_ADD, 3, 1, 2);
        prog[3] = rr(FN_SUB, 4, 1, 2);
        prog[4] = rr(FN_AND, 5, 1, 2);
        prog[5] = rr(FN_OR, 6, 1, 2);
        prog[6] = rr(FN_SLT, 7, 2, 1);
        prog[7] = rr(FN_SLT, 8, 1, 2);
        start();
        step("R3 addi pos", 32'd0, 1'b1, 5'd1, 32'd7);
        step("R3 addi neg", 32'd4, 1'b1, 5'd2, 32'hFFFF_FFFD);
        step("R2 add", 32'd8, 1'b1, 5'd3, 32'd4);
        step("R2 sub", 32'd12, 1'b1, 5'd4, 32'd10);
        step("R2 and", 32'd16, 1'b1, 5'd5, 32'd5);
        step("R2 or", 32'd20, 1'b1, 5'd6, 32'hFFFF_FFFF);
        step("R2 slt true", 32'd24, 1'b1, 5'd7, 32'd1);
        step("R2 slt false", 32'd28, 1'b1, 5'd8, 32'd0);
    endtask

    task automatic test_r0();
        clear_prog();
        prog[0] = ii(OPC_ADDI, 0, 0, 55);
        prog[1] = rr(FN_ADD, 9, 0, 0);
        prog[2] = ii(OPC_ADDI, 10, 0, 5);
        prog[3] = rr(FN_OR, 11, 0, 10);
        start();
        step("R6 r0 write on tap", 32'd0, 1'b1, 5'd0, 32'd55);
        step("R6 r0 reads zero", 32'd4, 1'b1, 5'd9, 32'd0);
        step("R9 tap addi", 32'd8, 1'b1, 5'd10, 32'd5);
        step("R9 readback r10", 32'd12, 1'b1, 5'd11, 32'd5);
    endtask

    task automatic test_mem();
        clear_prog();
        prog[0] = ii(OPC_ADDI, 1, 0, 32'h40);
        prog[1] = ii(OPC_ADDI, 2, 0, 32'h1234);
        prog[2] = ii(OPC_STORE, 2, 1, 8);
        prog[3] = ii(OPC_ADDI, 3, 0, -1);
        prog[4] = ii(OPC_STORE, 3, 1, 12);
        prog[5] = ii(OPC_LOAD, 4, 1, 8);
        prog[6] = ii(OPC_LOAD, 5, 1, 14);
        prog[7] = ii(OPC_ADDI, 6, 0, 32'h50);
        prog[8] = ii(OPC_LOAD, 7, 6, -8);
        prog[9] = ii(OPC_LOAD, 8, 0, 32'h14C);
        start();
        step("R3 base", 32'd0, 1'b1, 5'd1, 32'h40);
        step("R3 data", 32'd4, 1'b1, 5'd2, 32'h1234);
        step("R4 store no wb", 32'd8, 1'b0, 5'd0, 32'd0);
        step("R3 all ones", 32'd12, 1'b1, 5'd3, 32'hFFFF_FFFF);
        step("R4 store2 no wb", 32'd16, 1'b0, 5'd0, 32'd0);
        step("R4 load back", 32'd20, 1'b1, 5'd4, 32'h1234);
        step("R5 low bits ignored", 32'd24, 1'b1, 5'd5, 32'hFFFF_FFFF);
        step("R3 base2", 32'd28, 1'b1, 5'd6, 32'h50);
        step("R4 negative offset", 32'd32, 1'b1, 5'd7, 32'h1234);
        step("R5 upper bits ignored", 32'd36, 1'b1, 5'd8, 32'hFFFF_FFFF);
    endtask

    task automatic test_branch();
        clear_prog();
        prog[0] = ii(OPC_ADDI, 1, 0, 3);
        prog[1] = ii(OPC_ADDI, 2, 0, 3);
        prog[2] = ii(OPC_BEQ, 2, 1, 2);
        prog[3] = ii(OPC_ADDI, 3, 0, 99);
        prog[4] = ii(OPC_ADDI, 3, 0, 98);
        prog[5] = ii(OPC_ADDI, 4, 0, 1);
        prog[6] = ii(OPC_BEQ, 4, 1, 5);
        prog[7] = ii(OPC_BEQ, 4, 4, -2);
        start();
        step("R8 setup a", 32'd0, 1'b1, 5'd1, 32'd3);
        step("R8 setup b", 32'd4, 1'b1, 5'd2, 32'd3);
        step("R8 taken no wb", 32'd8, 1'b0, 5'd0, 32'd0);
        step("R8 forward target", 32'd20, 1'b1, 5'd4, 32'd1);
        step("R8 not taken", 32'd24, 1'b0, 5'd0, 32'd0);
        step("R7 fallthrough", 32'd28, 1'b0, 5'd0, 32'd0);
        step("R8 backward target", 32'd24, 1'b0, 5'd0, 32'd0);
        step("R8 loop again", 32'd28, 1'b0, 5'd0, 32'd0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        test_reset();
        test_alu();
        test_r0();
        test_mem();
        test_branch();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, got hung expected done");
            summary();
            $finish;
        end
    end

endmodule